// File: doc/BRIEF.md
# Multi-Mode GPIO Port Controller

This block controls a four-pin bidirectional I/O port through a small memory-mapped register set. Software selects each pin's direction, sets the output latch, enables pull-ups on inputs and selects open-drain drive on outputs. It can also read back the synchronized pad levels. The block drives per-pin output value, output enable, pull-up enable and open-drain control toward the pad ring. Pad circuitry is outside this block.

In external-bus operating modes (4, 5 and 6), a per-pin enable mask lets the address generator take over pins as address outputs. Those pins ignore the direction register. In every other mode the mask is ignored, so all pins are general I/O. A three-state standby sequencer tracks power state and has these states:
- ST_RUN: normal operation.
- ST_SW_STBY: software standby.
- ST_HW_STBY: hardware standby.

Its transitions are:
- RUN→SW_STBY on `sw_stby_req`.
- SW_STBY→RUN when the request drops.
- any state→HW_STBY on `hw_stby`.
- HW_STBY→RUN when `hw_stby` drops.
- any state→RUN on manual reset.

When the sequencer enters software standby, it captures the address bits and the hold select. Address pins then either keep driving the captured value or float.

Power-on reset and hardware standby clear all writable registers. Manual reset does not touch them; it only returns the sequencer to RUN.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), the direction, data, pull-up and open-drain registers are 0. Every `pin_oe`, `pin_pu` and `pin_od` bit is 0.
- R2: The direction register at 0xFE39 takes `bus_wdata[3:0]`, where a 1 makes a pin an output and a 0 makes it an input. A read of 0xFE39 returns the fixed pattern 0xA5, never the register.
- R3: The data register at 0xFF09 is read/write. A read returns the latch in bits [3:0] and 0 in bits [7:4]. A general-purpose output pin drives its data bit with `pin_oe`=1.
- R4: A read of 0xFFB9 returns, in bits [3:0], `pad_in` passed through a two-flop synchronizer, with 0 in bits [7:4]. A pad change set up before clock edge k is visible after edge k+1, for inputs and outputs alike.
- R5: When `op_mode` is 4, 5 or 6, a pin with its `addr_en` bit set drives `addr_bits` with `pin_oe`=1, whatever its direction bit holds. For any other `op_mode` value, `addr_en` has no effect.
- R6: The pull-up register at 0xFE40 is read/write. `pin_pu` equals the register bit only on general-purpose inputs and is 0 on every driven or address pin.
- R7: The open-drain register at 0xFE47 is read/write. On a general-purpose output with its open-drain bit set:
  - `pin_od`=1 and `pin_out`=0;
  - `pin_oe` is 0 when the data bit is 1, and 1 when it is 0;
  - elsewhere `pin_od` is 0.
- R8: While `hw_stby` is 1, `pin_out`, `pin_oe`, `pin_pu` and `pin_od` are all 0 in the same cycle. Every clock edge during standby clears the four registers, so bus writes are lost.
- R9: Manual reset (`mrst_n` low) leaves all four registers unchanged and returns the sequencer from software standby to RUN.
- R10: The clock edge that moves the sequencer from RUN to software standby captures `addr_bits` and `addr_hold_sel`. While in software standby, address pins with a captured select of 1 drive the captured bits with `pin_oe`=1. With a select of 0 they have `pin_oe`=0. General-purpose pins are unaffected.
- R11: A read with `bus_rd` low, or of any unmapped address, returns 0. A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, asynchronous, active low |
| hw_stby | input | 1 | Hardware standby request |
| sw_stby_req | input | 1 | Software standby request (level) |
| addr_hold_sel | input | 1 | 1: address pins hold in software standby; 0: they float |
| op_mode | input | 3 | Operating mode; 4 to 6 are external-bus modes |
| addr_en | input | 4 | Per-pin address-output enable |
| addr_bits | input | 4 | Address bits to drive on enabled pins |
| bus_addr | input | 16 | Register address (lower 16 bits) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 4 | Pad input levels (asynchronous) |
| pin_out | output | 4 | Per-pin output value |
| pin_oe | output | 4 | Per-pin output enable |
| pin_pu | output | 4 | Per-pin pull-up enable |
| pin_od | output | 4 | Per-pin open-drain control |

## Verification
The assertions check the following on every cycle:
- hardware standby silences all outputs at once and clears the registers by the next edge;
- no pin ever has a pull-up together with an output enable;
- an open-drain pin never drives a high level;
- in software standby, address pins are driven or floating according to the captured hold select.

The bench's scenarios cover what a property cannot express compactly:
- the complete pin function over every operating mode, direction and address-mask combination;
- the two-edge pad synchronizer latency;
- the fixed read pattern of the direction register;
- register retention across manual reset;
- the captured address value holding while the live address bits change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SW_STBY = 2'd1,
        ST_HW_STBY = 2'd2
    } stby_state_t;

    function automatic logic is_ext_mode(input logic [2:0] mode);
        return (mode == 3'd4) || (mode == 3'd5) || (mode == 3'd6);
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
    parameter int          NPINS       = 4,
    parameter int          AW          = 16,
    parameter int          DW          = 8,
    parameter logic [15:0] ADR_DIR     = 16'hFE39,
    parameter logic [15:0] ADR_DATA    = 16'hFF09,
    parameter logic [15:0] ADR_PINS    = 16'hFFB9,
    parameter logic [15:0] ADR_PULL    = 16'hFE40,
    parameter logic [15:0] ADR_ODRN    = 16'hFE47,
    parameter logic [7:0]  DIR_RD_PAT  = 8'hA5
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             hw_stby,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] data_q,
    output logic [NPINS-1:0] pull_q,
    output logic [NPINS-1:0] odrn_q
);

    localparam int PADW = DW - NPINS;

    logic [NPINS-1:0] sync1_q, sync2_q;
    logic sel_dir, sel_data, sel_pins, sel_pull, sel_odrn;

    assign sel_dir  = (bus_addr == AW'(ADR_DIR));
    assign sel_data = (bus_addr == AW'(ADR_DATA));
    assign sel_pins = (bus_addr == AW'(ADR_PINS));
    assign sel_pull = (bus_addr == AW'(ADR_PULL));
    assign sel_odrn = (bus_addr == AW'(ADR_ODRN));

    // Writable registers: power-on reset and hardware standby clear them.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            dir_q  <= '0;
            data_q <= '0;
            pull_q <= '0;
            odrn_q <= '0;
        end else if (hw_stby) begin
            dir_q  <= '0;
            data_q <= '0;
            pull_q <= '0;
            odrn_q <= '0;
        end else if (bus_wr) begin
            if (sel_dir)  dir_q  <= bus_wdata[NPINS-1:0];
            if (sel_data) data_q <= bus_wdata[NPINS-1:0];
            if (sel_pull) pull_q <= bus_wdata[NPINS-1:0];
            if (sel_odrn) odrn_q <= bus_wdata[NPINS-1:0];
        end
    end

    // Two-flop synchronizer for the pad levels.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pad_in;
            sync2_q <= sync1_q;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel_dir)       bus_rdata = DW'(DIR_RD_PAT);
            else if (sel_data) bus_rdata = {{PADW{1'b0}}, data_q};
            else if (sel_pins) bus_rdata = {{PADW{1'b0}}, sync2_q};
            else if (sel_pull) bus_rdata = {{PADW{1'b0}}, pull_q};
            else if (sel_odrn) bus_rdata = {{PADW{1'b0}}, odrn_q};
        end
    end

    // R8: a standby cycle leaves every writable register cleared after the edge
    a_r8_hw_clears_regs: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |=> (dir_q == '0) && (data_q == '0) && (pull_q == '0) && (odrn_q == '0));

    // R11: reads with the strobe low never return data
    a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!por_n)
        !bus_rd |-> (bus_rdata == '0));

endmodule

// File: rtl/gpio_port_stby_fsm.sv
module gpio_port_stby_fsm
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             mrst_n,
    input  logic             hw_stby,
    input  logic             sw_stby_req,
    input  logic             addr_hold_sel,
    input  logic [NPINS-1:0] addr_bits,
    output logic             sw_active,
    output logic             hold_sel_q,
    output logic [NPINS-1:0] hold_bits_q,
    output stby_state_t      state_q
);

    stby_state_t state_d;
    logic        enter_sw;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (hw_stby)          state_d = ST_HW_STBY;
                else if (sw_stby_req) state_d = ST_SW_STBY;
            end
            ST_SW_STBY: begin
                if (hw_stby)           state_d = ST_HW_STBY;
                else if (!sw_stby_req) state_d = ST_RUN;
            end
            ST_HW_STBY: begin
                if (!hw_stby)         state_d = ST_RUN;
            end
            default:                  state_d = ST_RUN;
        endcase
    end

    // State register: either reset returns to RUN.
    always_ff @(posedge clk or negedge por_n or negedge mrst_n) begin
        if (!por_n)       state_q <= ST_RUN;
        else if (!mrst_n) state_q <= ST_RUN;
        else              state_q <= state_d;
    end

    assign enter_sw = (state_q == ST_RUN) && (state_d == ST_SW_STBY);

    // Capture of the address value and hold select on standby entry.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hold_bits_q <= '0;
            hold_sel_q  <= 1'b0;
        end else if (enter_sw) begin
            hold_bits_q <= addr_bits;
            hold_sel_q  <= addr_hold_sel;
        end
    end

    always_comb begin
        sw_active = (state_q == ST_SW_STBY);
    end

    // R10: a request seen in RUN without hardware standby enters software standby
    a_r10_enter_sw: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
        (state_q == ST_RUN && sw_stby_req && !hw_stby) |=> (state_q == ST_SW_STBY));

    // R8: hardware standby wins over any other state
    a_r8_hw_state: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
        hw_stby |=> (state_q == ST_HW_STBY));

endmodule

// File: rtl/gpio_port_pin.sv
module gpio_port_pin (
    input  logic hw_stby,
    input  logic addr_pin,
    input  logic sw_active,
    input  logic hold_sel,
    input  logic hold_bit,
    input  logic addr_bit,
    input  logic dir_bit,
    input  logic data_bit,
    input  logic pull_bit,
    input  logic odrn_bit,
    output logic out_o,
    output logic oe_o,
    output logic pu_o,
    output logic od_o
);

    always_comb begin
        out_o = 1'b0;
        oe_o  = 1'b0;
        pu_o  = 1'b0;
        od_o  = 1'b0;
        if (hw_stby) begin
            // all off
        end else if (addr_pin) begin
            if (sw_active) begin
                out_o = hold_sel & hold_bit;
                oe_o  = hold_sel;
            end else begin
                out_o = addr_bit;
                oe_o  = 1'b1;
            end
        end else if (dir_bit) begin
            if (odrn_bit) begin
                oe_o = ~data_bit;
                od_o = 1'b1;
            end else begin
                out_o = data_bit;
                oe_o  = 1'b1;
            end
        end else begin
            pu_o = pull_bit;
        end
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int AW    = 16,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             mrst_n,
    input  logic             hw_stby,
    input  logic             sw_stby_req,
    input  logic             addr_hold_sel,
    input  logic [2:0]       op_mode,
    input  logic [NPINS-1:0] addr_en,
    input  logic [NPINS-1:0] addr_bits,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_pu,
    output logic [NPINS-1:0] pin_od
);

    logic [NPINS-1:0] dir_q, data_q, pull_q, odrn_q;
    logic [NPINS-1:0] hold_bits_q, amask;
    logic             sw_active, hold_sel_q;
    stby_state_t      state_q;

    assign amask = is_ext_mode(op_mode) ? addr_en : '0;

    gpio_port_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) regs_i (
        .clk       (clk),
        .por_n     (por_n),
        .hw_stby   (hw_stby),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .dir_q     (dir_q),
        .data_q    (data_q),
        .pull_q    (pull_q),
        .odrn_q    (odrn_q)
    );

    gpio_port_stby_fsm #(.NPINS(NPINS)) fsm_i (
        .clk           (clk),
        .por_n         (por_n),
        .mrst_n        (mrst_n),
        .hw_stby       (hw_stby),
        .sw_stby_req   (sw_stby_req),
        .addr_hold_sel (addr_hold_sel),
        .addr_bits     (addr_bits),
        .sw_active     (sw_active),
        .hold_sel_q    (hold_sel_q),
        .hold_bits_q   (hold_bits_q),
        .state_q       (state_q)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_port_pin pin_i (
            .hw_stby  (hw_stby),
            .addr_pin (amask[i]),
            .sw_active(sw_active),
            .hold_sel (hold_sel_q),
            .hold_bit (hold_bits_q[i]),
            .addr_bit (addr_bits[i]),
            .dir_bit  (dir_q[i]),
            .data_bit (data_q[i]),
            .pull_bit (pull_q[i]),
            .odrn_bit (odrn_q[i]),
            .out_o    (pin_out[i]),
            .oe_o     (pin_oe[i]),
            .pu_o     (pin_pu[i]),
            .od_o     (pin_od[i])
        );
    end

    // R8: hardware standby silences every pin in the same cycle
    a_r8_hw_outputs_off: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |-> (pin_oe == '0) && (pin_pu == '0) && (pin_od == '0));

    // R6: a pull-up is never enabled on a driven pin
    a_r6_pull_only_inputs: assert property (@(posedge clk) disable iff (!por_n)
        (pin_pu & pin_oe) == '0);

    // R7: an open-drain pin never drives a high level
    a_r7_odrn_never_high: assert property (@(posedge clk) disable iff (!por_n)
        (pin_od & pin_oe & pin_out) == '0);

    // R10: held address pins stay driven in software standby
    a_r10_sw_hold_driven: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_SW_STBY && hold_sel_q && !hw_stby) |-> ((pin_oe & amask) == amask));

    // R10: released address pins float in software standby
    a_r10_sw_float: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_SW_STBY && !hold_sel_q) |-> ((pin_oe & amask) == '0));

    // R5: outside software and hardware standby an address pin follows the live address
    a_r5_addr_follow: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_RUN && !hw_stby) |-> (((pin_out ^ addr_bits) & amask) == '0));

endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 150000;
    localparam logic [15:0] A_DIR  = 16'hFE39;
    localparam logic [15:0] A_DATA = 16'hFF09;
    localparam logic [15:0] A_PINS = 16'hFFB9;
    localparam logic [15:0] A_PULL = 16'hFE40;
    localparam logic [15:0] A_ODRN = 16'hFE47;

    logic        clk = 1'b0;
    logic        por_n, mrst_n, hw_stby, sw_stby_req, addr_hold_sel;
    logic [2:0]  op_mode;
    logic [3:0]  addr_en, addr_bits, pad_in;
    logic [15:0] bus_addr;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [3:0]  pin_out, pin_oe, pin_pu, pin_od;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_ctrl dut_i (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
        .sw_stby_req(sw_stby_req), .addr_hold_sel(addr_hold_sel),
        .op_mode(op_mode), .addr_en(addr_en), .addr_bits(addr_bits),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_od(pin_od)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(req, {24'h0, bus_rdata}, {24'h0, exp});
        bus_rd = 1'b0;
    endtask

    function automatic logic [15:0] model(input logic [2:0] m, input logic [3:0] aen,
                                          input logic [3:0] ab, input logic [3:0] dr,
                                          input logic [3:0] dt, input logic [3:0] od,
                                          input logic [3:0] pu);
        logic [3:0] o, e, p, q;
        logic ext;
        ext = (m >= 3'd4) && (m <= 3'd6);
        for (int i = 0; i < 4; i++) begin
            o[i] = 0; e[i] = 0; p[i] = 0; q[i] = 0;
            if (ext && aen[i]) begin
                o[i] = ab[i]; e[i] = 1;
            end else if (dr[i]) begin
                if (od[i]) begin e[i] = ~dt[i]; q[i] = 1; end
                else begin o[i] = dt[i]; e[i] = 1; end
            end else begin
                p[i] = pu[i];
            end
        end
        return {o, e, p, q};
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        por_n = 0; mrst_n = 1; hw_stby = 0; sw_stby_req = 0; addr_hold_sel = 0;
        op_mode = 3'd7; addr_en = 0; addr_bits = 0; pad_in = 0;
        bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
        repeat (3) @(negedge clk);
        // R1: reset state at the pins and in readable registers
        #1;
        chk("R1 pins", {16'h0, pin_oe, pin_pu, pin_od, 4'h0}, 32'h0);
        por_n = 1;
        @(negedge clk);
        rd_chk("R1 data", A_DATA, 8'h00);
        rd_chk("R1 pull", A_PULL, 8'h00);
        rd_chk("R1 odrn", A_ODRN, 8'h00);

        // R2 R3 R6 R7: readback of each register for all 16 values
        for (int v = 0; v < 16; v++) begin
            wr(A_DIR,  8'(v) | 8'hF0);
            wr(A_DATA, 8'(v ^ 5) | 8'hF0);
            wr(A_PULL, 8'(15 - v));
            wr(A_ODRN, 8'(v ^ 10));
            rd_chk("R2 dir read pattern", A_DIR, 8'hA5);
            rd_chk("R3 data readback", A_DATA, 8'(v ^ 5));
            rd_chk("R6 pull readback", A_PULL, 8'(15 - v));
            rd_chk("R7 odrn readback", A_ODRN, 8'(v ^ 10));
        end

        // R11: unmapped write and read, idle read
        wr(A_DATA, 8'h06);
        wr(16'hFE38, 8'h0F);
        wr(16'hFF0A, 8'h0F);
        rd_chk("R11 unmapped write", A_DATA, 8'h06);
        rd_chk("R11 unmapped read", 16'hFE41, 8'h00);
        bus_addr = A_DATA; #1;
        chk("R11 idle read", {24'h0, bus_rdata}, 32'h0);

        // R2 R3 R5 R6 R7: full sweep of mode, direction and address mask
        for (int m = 0; m < 8; m++) begin
            for (int d = 0; d < 16; d++) begin
                op_mode = 3'(m);
                wr(A_DIR, 8'(d));
                for (int a = 0; a < 16; a++) begin
                    logic [3:0] dt, od, pu, ab;
                    dt = 4'(a ^ d ^ 5);
                    od = {4'(a)}[0] ? 4'(a) : 4'(~a);
                    pu = 4'(~a);
                    ab = 4'(d ^ 9);
                    wr(A_DATA, {4'h0, dt});
                    wr(A_ODRN, {4'h0, od});
                    wr(A_PULL, {4'h0, pu});
                    addr_en = 4'(a); addr_bits = ab;
                    #1;
                    chk("R5 R6 R7 pin sweep", {16'h0, pin_out, pin_oe, pin_pu, pin_od},
                        {16'h0, model(3'(m), 4'(a), ab, 4'(d), dt, od, pu)});
                    @(negedge clk);
                end
            end
        end

        // R4: synchronizer latency for every pad value
        for (int p = 0; p < 16; p++) begin
            logic [3:0] prev;
            prev = 4'(p - 1);
            pad_in = 4'(p);
            @(posedge clk); @(negedge clk);
            rd_chk("R4 one edge old", A_PINS, p == 0 ? 8'h00 : {4'h0, prev});
            @(posedge clk); @(negedge clk);
            rd_chk("R4 two edges new", A_PINS, 8'(p));
        end

        // R9: manual reset keeps registers
        op_mode = 3'd7; addr_en = 0;
        wr(A_DIR, 8'h0C); wr(A_DATA, 8'h09); wr(A_PULL, 8'h03); wr(A_ODRN, 8'h08);
        mrst_n = 0; @(negedge clk); mrst_n = 1; @(negedge clk);
        rd_chk("R9 data kept", A_DATA, 8'h09);
        rd_chk("R9 pull kept", A_PULL, 8'h03);
        rd_chk("R9 odrn kept", A_ODRN, 8'h08);
        #1;
        chk("R9 dir kept at pins", {24'h0, pin_oe}, {28'h0, 4'h4});

        // R10: software standby with hold select 1
        op_mode = 3'd5; addr_en = 4'h3; addr_bits = 4'h1; addr_hold_sel = 1;
        sw_stby_req = 1;
        @(posedge clk); @(negedge clk);
        addr_bits = 4'hE; addr_hold_sel = 0; #1;
        chk("R10 hold value", {28'h0, pin_out[1:0]}, 32'h1);
        chk("R10 hold oe", {28'h0, pin_oe}, 32'h7);
        // R9: manual reset leaves software standby
        mrst_n = 0; @(negedge clk); mrst_n = 1; #1;
        chk("R9 mrst exits standby", {28'h0, pin_out[1:0]}, 32'h2);
        sw_stby_req = 0; @(negedge clk);

        // R10: software standby with hold select 0
        addr_bits = 4'h3; addr_hold_sel = 0; sw_stby_req = 1;
        @(posedge clk); @(negedge clk); #1;
        chk("R10 float oe", {28'h0, pin_oe}, 32'h4);
        chk("R10 gp pin unaffected", {28'h0, pin_out}, 32'h0);
        sw_stby_req = 0; @(posedge clk); @(negedge clk); #1;
        chk("R10 exit follows live", {28'h0, pin_out[1:0]}, 32'h3);

        // R8: hardware standby
        op_mode = 3'd7; addr_en = 0;
        wr(A_DIR, 8'h05); wr(A_DATA, 8'h0F); wr(A_PULL, 8'h0A); wr(A_ODRN, 8'h00);
        hw_stby = 1; #1;
        chk("R8 immediate off", {16'h0, pin_out, pin_oe, pin_pu, pin_od}, 32'h0);
        wr(A_DATA, 8'h0C);
        hw_stby = 0; @(negedge clk);
        rd_chk("R8 data cleared", A_DATA, 8'h00);
        rd_chk("R8 pull cleared", A_PULL, 8'h00);
        #1;
        chk("R8 dir cleared at pins", {24'h0, pin_oe}, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule